// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns an 8-bit parallel word into a serial bit stream through two register stages. A holding register takes a snapshot of the parallel inputs on each rising edge of a capture strobe. A separate shift register either copies that held word or advances by one stage on each rising edge of a shift strobe. While it advances, it takes a new bit at its low end from a serial input.

The highest stage of the shift register drives a single serial output pin. That pin can be released to high impedance so that several sources can share one line. A second output always shows the same stage with no gating, so logic inside the chip can follow the stream while the pin is released.

Both strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer and an edge detector. The mode select is level-sensitive: while it is low, the shift register follows the holding register on every system clock cycle.

Top module: `piso_latched_shifter`

## Requirements
- R1: While rst_n is low, and right after it rises, both registers hold zero, so stage_tap is 0 and ser_out is high impedance while oe_n is high.
- R2: A rising edge on cap_strobe loads par_in into the holding register, whatever the levels of mode_shift, shf_strobe and oe_n.
- R3: While mode_shift is 0, the shift register is reloaded from the holding register on every clock cycle, and rising edges on shf_strobe have no effect.
- R4: When cap_strobe rises while mode_shift is 0, the new par_in word reaches the shift register on the same clock edge that updates the holding register.
- R5: While mode_shift is 1, each rising edge on shf_strobe moves stage n to stage n+1 and loads ser_in into stage 0. With no such edge, the shift register holds its value.
- R6: par_in[0] loads stage 0 and par_in[7] loads stage 7. Stage 7 is the first bit to appear at the output, and par_in[0] appears after 7 shifts.
- R7: When oe_n is 1, ser_out is high impedance. When oe_n is 0 (and rst_n is 1), ser_out drives stage 7.
- R8: When both strobes rise in the same cycle with mode_shift at 1, the shift uses the old contents of the shift register, and the holding register still takes the new par_in.
- R9: stage_tap always shows stage 7, with no dependence on oe_n.
- R10: A strobe level change that the clock first samples at rising edge k updates the registers at rising edge k+2. Each strobe rise takes effect exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | 8 | Parallel data word; bit 0 goes to stage 0 |
| ser_in | input | 1 | Serial bit shifted into stage 0 |
| cap_strobe | input | 1 | Asynchronous capture strobe, acts on its rising edge |
| shf_strobe | input | 1 | Asynchronous shift strobe, acts on its rising edge |
| mode_shift | input | 1 | 0 = reload from the holding register, 1 = shift |
| oe_n | input | 1 | Active-low output enable |
| ser_out | output | 1 | Stage 7 when enabled, otherwise high impedance |
| stage_tap | output | 1 | Stage 7 with no gating |

## Verification
Any wrong bit in the shift register appears at stage_tap within eight shift strobes. It reaches the tap at once when it sits in stage 7. A wrong bit in the holding register stays out of sight until the next reload while the mode is low, and then reaches the tap through the same shifting. The bench therefore follows each reload with a full readout of the word. A wrong strobe latency shows as a tap value that changes one clock edge too early or too late.

// File: rtl/piso_pkg.sv
package piso_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD       = 2'd0,
        ACT_FROM_STORE = 2'd1,
        ACT_FROM_PAR   = 2'd2,
        ACT_SHIFT      = 2'd3
    } shf_act_e;
endpackage

// File: rtl/piso_edge_sync.sv
module piso_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.pipe = {st_q.pipe[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.pipe[STAGES-1] & ~st_q.pipe[STAGES];
endmodule

// File: rtl/piso_core.sv
module piso_core
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             mode_shift,
    input  logic             cap_rise,
    input  logic             shf_rise,
    output logic [WIDTH-1:0] store_val,
    output logic [WIDTH-1:0] shift_val
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [MSB:0] store;
        logic [MSB:0] shreg;
    } core_t;

    core_t    st_d, st_q;
    shf_act_e act;

    always_comb begin
        if (!mode_shift)    act = cap_rise ? ACT_FROM_PAR : ACT_FROM_STORE;
        else if (shf_rise)  act = ACT_SHIFT;
        else                act = ACT_HOLD;

        st_d = st_q;
        if (cap_rise) st_d.store = par_in;
        case (act)
            ACT_FROM_STORE: st_d.shreg = st_q.store;
            ACT_FROM_PAR:   st_d.shreg = par_in;
            ACT_SHIFT:      st_d.shreg = {st_q.shreg[MSB-1:0], ser_in};
            default:        st_d.shreg = st_q.shreg;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store_val = st_q.store;
    assign shift_val = st_q.shreg;
endmodule

// File: rtl/piso_latched_shifter.sv
module piso_latched_shifter #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             cap_strobe,
    input  logic             shf_strobe,
    input  logic             mode_shift,
    input  logic             oe_n,
    output logic             ser_out,
    output logic             stage_tap
);
    localparam int MSB = WIDTH - 1;

    logic             cap_rise, shf_rise;
    logic [WIDTH-1:0] store_val, shift_val;

    piso_edge_sync #(.STAGES(SYNC_STAGES)) cap_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(cap_strobe), .rise(cap_rise)
    );

    piso_edge_sync #(.STAGES(SYNC_STAGES)) shf_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(shf_strobe), .rise(shf_rise)
    );

    piso_core #(.WIDTH(WIDTH)) core_i (
        .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
        .mode_shift(mode_shift), .cap_rise(cap_rise), .shf_rise(shf_rise),
        .store_val(store_val), .shift_val(shift_val)
    );

    assign stage_tap = shift_val[MSB];
    assign ser_out   = (!oe_n && rst_n) ? shift_val[MSB] : 1'bz;
endmodule

// File: rtl/piso_latched_shifter_chk.sv
module piso_latched_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_in,
    input logic             mode_shift,
    input logic             cap_rise,
    input logic             shf_rise,
    input logic [WIDTH-1:0] store_val,
    input logic [WIDTH-1:0] shift_val,
    input logic             stage_tap
);
    localparam int MSB = WIDTH - 1;

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_rise) |-> store_val == $past(par_in)); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mode_shift) && $past(!cap_rise)) |-> shift_val == $past(store_val)); // R3
    AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mode_shift) && $past(cap_rise)) |-> shift_val == $past(par_in)); // R4
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_shift) && $past(shf_rise))
            |-> shift_val == {$past(shift_val[MSB-1:0]), $past(ser_in)}); // R8
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_shift) && $past(!shf_rise)) |-> $stable(shift_val)); // R5
    AST_TAP_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_tap == shift_val[MSB]); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rise |=> !cap_rise) and (shf_rise |=> !shf_rise)); // R10
endmodule

bind piso_latched_shifter piso_latched_shifter_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
    .mode_shift(mode_shift), .cap_rise(cap_rise), .shf_rise(shf_rise),
    .store_val(store_val), .shift_val(shift_val), .stage_tap(stage_tap)
);

// File: tb/piso_latched_shifter_tb_top.sv
`timescale 1ns/1ps
module piso_latched_shifter_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] par_in = 0;
    logic       ser_in = 0, cap_strobe = 0, shf_strobe = 0, mode_shift = 0, oe_n = 1;
    logic       ser_out, stage_tap;

    int checks = 0, fails = 0;
    logic [7:0] m_store = 0, m_shreg = 0;

    always #5 clk = ~clk;

    piso_latched_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
        .cap_strobe(cap_strobe), .shf_strobe(shf_strobe), .mode_shift(mode_shift),
        .oe_n(oe_n), .ser_out(ser_out), .stage_tap(stage_tap)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic exp_out(logic o, logic [7:0] sr);
        return o ? 1'bz : sr[7];
    endfunction

    task automatic chk_out(string tag);
        chk(stage_tap === m_shreg[7], {tag, " R9 tap"}, {7'd0, stage_tap}, {7'd0, m_shreg[7]});
        chk(ser_out === exp_out(oe_n, m_shreg), {tag, " R7 pin"}, {7'd0, ser_out},
            {7'd0, exp_out(oe_n, m_shreg)});
    endtask

    // pulse the chosen strobes; model updates when the pulse takes effect
    task automatic strobe(bit c, bit s);
        cap_strobe = c; shf_strobe = s;
        tick(3);
        if (s && mode_shift) m_shreg = {m_shreg[6:0], ser_in};
        if (c) m_store = par_in;
        if (!mode_shift) m_shreg = m_store;
        cap_strobe = 0; shf_strobe = 0;
        tick(3);
    endtask

    task automatic set_mode(bit m);
        mode_shift = m;
        tick(1);
        if (!m) m_shreg = m_store;
    endtask

    // shift out the whole word, checking every bit in order (R6, R5)
    task automatic read_word(logic [7:0] exp_w, string tag);
        set_mode(1);
        for (int i = 7; i >= 0; i--) begin
            chk(stage_tap === exp_w[i], {tag, " R6 order"}, {7'd0, stage_tap}, {7'd0, exp_w[i]});
            ser_in = 0;
            strobe(0, 1);
        end
    endtask

    initial begin
        tick(50000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        chk(stage_tap === 1'b0, "R1 reset tap", {7'd0, stage_tap}, 8'd0);
        chk(ser_out === 1'bz, "R1 reset pin", {7'd0, ser_out}, 8'd0);
        oe_n = 0; tick(1);
        chk(ser_out === 1'bz, "R1 pin in reset", {7'd0, ser_out}, 8'd0);
        oe_n = 1;
        rst_n = 1; tick(2);
        chk_out("R1 after reset");

        // R2/R6: capture in load mode, full readout
        par_in = 8'b1011_0010; strobe(1, 0); chk_out("R2 cap");
        read_word(8'b1011_0010, "R2");

        // R3: shift strobe ignored while loading
        set_mode(0); chk_out("R3 reload");
        ser_in = 1; strobe(0, 1); strobe(0, 1); chk_out("R3 ignore");
        read_word(8'b1011_0010, "R3");

        // R2: capture while shifting does not touch shift register
        set_mode(1); par_in = 8'b0110_1101; strobe(1, 0); chk_out("R2 shiftmode");
        set_mode(0); read_word(8'b0110_1101, "R2 reload");

        // R10 latency + R4 flow-through
        set_mode(0); par_in = 8'h00; strobe(1, 0);
        par_in = 8'h80; cap_strobe = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(stage_tap === 1'b0, "R10 not early", {7'd0, stage_tap}, 8'd0);
        tick(1);
        chk(stage_tap === 1'b1, "R10 on time / R4", {7'd0, stage_tap}, 8'd1);
        m_store = 8'h80; m_shreg = 8'h80;
        cap_strobe = 0; tick(3);
        read_word(8'h80, "R4");

        // R8: simultaneous strobes
        set_mode(0); par_in = 8'hC3; strobe(1, 0); set_mode(1);
        par_in = 8'h5A; ser_in = 1; strobe(1, 1);
        chk_out("R8 both");
        read_word({8'hC3} << 1 | 8'h01, "R8 old shifted");
        set_mode(0); read_word(8'h5A, "R8 new stored");

        // R7: enable toggles
        oe_n = 0; tick(1); chk_out("R7 on");
        oe_n = 1; tick(1); chk_out("R7 off");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 4);
            par_in = 8'($urandom);
            ser_in = 1'($urandom);
            case (op)
                0: strobe(1, 0);
                1: strobe(0, 1);
                2: strobe(1, 1);
                3: set_mode(1'($urandom));
                default: begin oe_n = 1'($urandom); tick(1); end
            endcase
            chk_out("R5 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule